// File: doc/BRIEF.md
# ATM Cell Header Filter Bank

This block sits on the receive path of an ATM cell stream. It takes cells as a byte stream, one byte per valid beat, with a start-of-cell marker on the first byte. It compares the 4-byte cell header against four user filters that run in parallel. Each filter has a control nibble, a 32-bit pattern and a 32-bit compare mask. An enabled filter that selects a cell can drop the cell from the forward path, copy it into a one-cell extraction buffer that a host reads, or do both.

The forward output runs a fixed four byte-clocks behind the input. This delay lets the drop decision settle before the first header byte leaves the block, so a dropped cell produces no output beats at all. The extraction buffer holds one 53-byte cell and raises a cell-available flag. While that flag is set, further copy requests are refused and an overflow flag records them. A single clear pulse from the host frees the buffer again.

Top module: `atm_hdr_filter`

## Requirements
- R1: Each filter f takes its control nibble from cfg_ctrl_i[4f+3:4f]. Bit 3 is enable, bit 2 is copy, bit 1 is discard and bit 0 is sense. A filter whose enable bit is 0 never drops or copies a cell, whatever the other bits are.
- R2: Take the header as {byte0, byte1, byte2, byte3}, with byte0 in the top bits. A filter matches when (header AND check) equals (pattern AND check). Header bits whose check bit is 0 have no effect on the match.
- R3: With sense 0, an enabled filter selects matching cells. With sense 1, it selects cells that do not match.
- R4: If any selecting filter has discard set, the whole cell is dropped and fwd_valid_o stays low for all 53 of its bytes. The discard bits of all selecting filters are ORed together.
- R5: A cell that is not dropped appears on fwd_data_o unchanged. Byte k of the cell is output exactly 4 cycles after it is input, with fwd_valid_o high on every beat.
- R6: If any selecting filter has copy set and the buffer is free, all 53 bytes are stored. host_avail_o rises the cycle after the last byte, and host_rdata_o shows byte k while host_addr_i = k.
- R7: A filter with both copy and discard set stores the cell in the buffer and also drops it from the forward path.
- R8: When several selecting filters have copy set, host_hit_o shows the lowest-numbered one. host_hit_o is stable while host_avail_o is high.
- R9: A copy request that arrives while host_avail_o is high sets host_ovf_o and leaves the stored cell unchanged. host_ovf_o then stays set until the host clears it.
- R10: A one-cycle host_clr_i pulse clears host_avail_o and host_ovf_o on the next cycle. If it coincides with a set, the clear wins.
- R11: After reset, fwd_valid_o, host_avail_o and host_ovf_o are low.
- R12: A cell_sop_i beat always restarts the byte count at byte 0. A complete cell that follows a truncated fragment is still filtered on its own header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cell_data_i | input | 8 | Incoming cell byte |
| cell_valid_i | input | 1 | Byte valid; held high for all 53 bytes of a cell |
| cell_sop_i | input | 1 | Marks byte 0 of a cell |
| cfg_ctrl_i | input | 16 | Four control nibbles {en, copy, discard, sense} |
| cfg_pattern_i | input | 128 | Four 32-bit header patterns |
| cfg_check_i | input | 128 | Four 32-bit compare masks |
| fwd_data_o | output | 8 | Forwarded byte |
| fwd_valid_o | output | 1 | Forwarded byte valid |
| fwd_sop_o | output | 1 | Forwarded byte 0 marker |
| host_addr_i | input | 6 | Extraction buffer byte address |
| host_rdata_o | output | 8 | Byte read from the extraction buffer |
| host_clr_i | input | 1 | Clears the available and overflow flags |
| host_avail_o | output | 1 | A captured cell is waiting |
| host_ovf_o | output | 1 | A copy request was refused |
| host_hit_o | output | 2 | Filter that captured the stored cell |

## Verification
Each forwarded byte is due exactly four cycles after it is input. The bench stamps the cycle of byte 0 and compares it with the cycle of the first output beat. The drop decision, the available flag, the filter id and the overflow flag are all settled one cycle after the last byte, so the bench reads them only after eight idle cycles. Buffer reads are combinational and are taken a delta after the address is set. The clear takes effect on the cycle after the pulse and is sampled at the following falling edge.

// File: rtl/atm_filt_pkg.sv
package atm_filt_pkg;
  localparam int unsigned CELL_BYTES = 53;
  localparam int unsigned HDR_BYTES  = 4;
  localparam int unsigned CTL_W      = 4;
  localparam int unsigned CTL_EN     = 3;
  localparam int unsigned CTL_CPY    = 2;
  localparam int unsigned CTL_DIS    = 1;
  localparam int unsigned CTL_SNS    = 0;

  typedef struct packed {
    logic       sop;
    logic       vld;
    logic [7:0] data;
  } beat_t;
endpackage

// File: rtl/atm_hdr_match.sv
module atm_hdr_match
  import atm_filt_pkg::*;
#(
  parameter int unsigned HW = 8 * HDR_BYTES
) (
  input  logic [HW-1:0]    hdr_i,
  input  logic [CTL_W-1:0] ctrl_i,
  input  logic [HW-1:0]    pat_i,
  input  logic [HW-1:0]    chk_i,
  output logic             copy_o,
  output logic             drop_o
);
  logic hit, act;
  assign hit    = ((hdr_i ^ pat_i) & chk_i) == '0;
  assign act    = ctrl_i[CTL_EN] & (hit ^ ctrl_i[CTL_SNS]);
  assign copy_o = act & ctrl_i[CTL_CPY];
  assign drop_o = act & ctrl_i[CTL_DIS];
endmodule

// File: rtl/atm_act_resolve.sv
module atm_act_resolve #(
  parameter int unsigned NF = 4,
  localparam int unsigned FW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic [NF-1:0] copy_i,
  input  logic [NF-1:0] drop_i,
  output logic          any_copy_o,
  output logic          any_drop_o,
  output logic [FW-1:0] sel_o
);
  assign any_copy_o = |copy_i;
  assign any_drop_o = |drop_i;

  // lowest index wins
  always_comb begin
    sel_o = '0;
    for (int f = NF - 1; f >= 0; f--) begin
      if (copy_i[f]) sel_o = FW'(f);
    end
  end
endmodule

// File: rtl/atm_fwd_delay.sv
module atm_fwd_delay
  import atm_filt_pkg::*;
#(
  parameter int unsigned DEPTH = HDR_BYTES
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  beat_t beat_i,
  output beat_t beat_o
);
  beat_t stg_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= beat_i;
      else stg_q[s] <= stg_q[s-1];
    end
  end

  assign beat_o = stg_q[DEPTH-1];
endmodule

// File: rtl/atm_extract_buf.sv
module atm_extract_buf
  import atm_filt_pkg::*;
#(
  parameter int unsigned NF = 4,
  localparam int unsigned FW = (NF > 1) ? $clog2(NF) : 1,
  localparam int unsigned IW = $clog2(CELL_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic          sop_i,
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    data_i,
  input  logic          decide_i,
  input  logic          copy_req_i,
  input  logic [FW-1:0] sel_i,
  input  logic [IW-1:0] host_addr_i,
  input  logic          host_clr_i,
  output logic [7:0]    host_rdata_o,
  output logic          host_avail_o,
  output logic          host_ovf_o,
  output logic [FW-1:0] host_hit_o
);
  logic [7:0]    mem_q [CELL_BYTES];
  logic          cap_q, copy_q, avail_q, ovf_q;
  logic [FW-1:0] sel_q, hit_q;
  logic          cap_now, last;

  // a cell is captured only if the buffer was free at its first byte
  assign cap_now = sop_i ? ~avail_q : cap_q;
  assign last    = vld_i & (idx_i == IW'(CELL_BYTES - 1));

  always_ff @(posedge clk_i) begin
    if (vld_i && cap_now && idx_i < IW'(CELL_BYTES)) mem_q[idx_i] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= 1'b0;
      copy_q  <= 1'b0;
      sel_q   <= '0;
      avail_q <= 1'b0;
      ovf_q   <= 1'b0;
      hit_q   <= '0;
    end else begin
      if (vld_i && sop_i) cap_q <= ~avail_q;
      if (decide_i) begin
        copy_q <= copy_req_i;
        sel_q  <= sel_i;
      end
      if (host_clr_i) begin
        avail_q <= 1'b0;
        ovf_q   <= 1'b0;
      end else begin
        if (last && cap_q && copy_q) begin
          avail_q <= 1'b1;
          hit_q   <= sel_q;
        end
        if (decide_i && copy_req_i && !cap_q) ovf_q <= 1'b1;
      end
    end
  end

  assign host_rdata_o = (host_addr_i < IW'(CELL_BYTES)) ? mem_q[host_addr_i] : 8'h00;
  assign host_avail_o = avail_q;
  assign host_ovf_o   = ovf_q;
  assign host_hit_o   = hit_q;
endmodule

// File: rtl/atm_hdr_filter.sv
module atm_hdr_filter
  import atm_filt_pkg::*;
#(
  parameter int unsigned NF = 4,
  localparam int unsigned HW = 8 * HDR_BYTES,
  localparam int unsigned FW = (NF > 1) ? $clog2(NF) : 1,
  localparam int unsigned IW = $clog2(CELL_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       cell_data_i,
  input  logic             cell_valid_i,
  input  logic             cell_sop_i,
  input  logic [NF*CTL_W-1:0] cfg_ctrl_i,
  input  logic [NF*HW-1:0] cfg_pattern_i,
  input  logic [NF*HW-1:0] cfg_check_i,
  output logic [7:0]       fwd_data_o,
  output logic             fwd_valid_o,
  output logic             fwd_sop_o,
  input  logic [IW-1:0]    host_addr_i,
  output logic [7:0]       host_rdata_o,
  input  logic             host_clr_i,
  output logic             host_avail_o,
  output logic             host_ovf_o,
  output logic [FW-1:0]    host_hit_o
);
  localparam int unsigned PW = HW - 8;

  logic [IW-1:0] cnt_q, idx;
  logic [PW-1:0] hdr_q;
  logic [HW-1:0] hdr_w;
  logic          decide, drop_q;
  logic [NF-1:0] copy_v, drop_v;
  logic          any_copy, any_drop;
  logic [FW-1:0] sel;
  beat_t         beat_in, beat_out;

  assign idx    = cell_sop_i ? '0 : cnt_q;
  assign decide = cell_valid_i & (idx == IW'(HDR_BYTES - 1));
  assign hdr_w  = {hdr_q, cell_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hdr_q  <= '0;
      drop_q <= 1'b0;
    end else if (cell_valid_i) begin
      if (idx < IW'(CELL_BYTES)) cnt_q <= idx + 1'b1;
      if (idx < IW'(HDR_BYTES - 1)) hdr_q <= {hdr_q[PW-9:0], cell_data_i};
      if (decide) drop_q <= any_drop;
    end
  end

  for (genvar f = 0; f < NF; f++) begin : g_flt
    atm_hdr_match #(.HW(HW)) i_match (
      .hdr_i  (hdr_w),
      .ctrl_i (cfg_ctrl_i[f*CTL_W +: CTL_W]),
      .pat_i  (cfg_pattern_i[f*HW +: HW]),
      .chk_i  (cfg_check_i[f*HW +: HW]),
      .copy_o (copy_v[f]),
      .drop_o (drop_v[f])
    );
  end

  atm_act_resolve #(.NF(NF)) i_resolve (
    .copy_i     (copy_v),
    .drop_i     (drop_v),
    .any_copy_o (any_copy),
    .any_drop_o (any_drop),
    .sel_o      (sel)
  );

  assign beat_in = '{sop: cell_sop_i & cell_valid_i, vld: cell_valid_i, data: cell_data_i};

  atm_fwd_delay #(.DEPTH(HDR_BYTES)) i_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (beat_in),
    .beat_o (beat_out)
  );

  // drop_q updates on the edge that loads byte 0 into the last stage
  assign fwd_valid_o = beat_out.vld & ~drop_q;
  assign fwd_sop_o   = beat_out.sop & ~drop_q;
  assign fwd_data_o  = beat_out.data;

  atm_extract_buf #(.NF(NF)) i_xbuf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vld_i        (cell_valid_i),
    .sop_i        (cell_sop_i),
    .idx_i        (idx),
    .data_i       (cell_data_i),
    .decide_i     (decide),
    .copy_req_i   (any_copy),
    .sel_i        (sel),
    .host_addr_i  (host_addr_i),
    .host_clr_i   (host_clr_i),
    .host_rdata_o (host_rdata_o),
    .host_avail_o (host_avail_o),
    .host_ovf_o   (host_ovf_o),
    .host_hit_o   (host_hit_o)
  );
endmodule

// File: rtl/atm_hdr_filter_chk.sv
module atm_hdr_filter_chk #(
  parameter int unsigned FW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    cell_data_i,
  input logic          cell_valid_i,
  input logic [7:0]    fwd_data_o,
  input logic          fwd_valid_o,
  input logic          host_clr_i,
  input logic          host_avail_o,
  input logic          host_ovf_o,
  input logic [FW-1:0] host_hit_o
);
  // R5
  fwd_src_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> $past(cell_valid_i, 4));
  // R5
  fwd_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> fwd_data_o == $past(cell_data_i, 4));
  // R6
  avail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_avail_o && !host_clr_i |=> host_avail_o);
  // R8
  hit_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_avail_o && !host_clr_i |=> $stable(host_hit_o));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ovf_o && !host_clr_i |=> host_ovf_o);
  // R10
  clr_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_clr_i |=> !host_avail_o && !host_ovf_o);
endmodule

bind atm_hdr_filter atm_hdr_filter_chk #(.FW(FW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cell_data_i  (cell_data_i),
  .cell_valid_i (cell_valid_i),
  .fwd_data_o   (fwd_data_o),
  .fwd_valid_o  (fwd_valid_o),
  .host_clr_i   (host_clr_i),
  .host_avail_o (host_avail_o),
  .host_ovf_o   (host_ovf_o),
  .host_hit_o   (host_hit_o)
);

// File: tb/test_atm_hdr_filter.sv
`timescale 1ns/1ps
module test_atm_hdr_filter;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [7:0]   cell_data_i = '0;
  logic         cell_valid_i = 1'b0;
  logic         cell_sop_i = 1'b0;
  logic [3:0]   ctl [4];
  logic [31:0]  pat [4];
  logic [31:0]  chk [4];
  logic [15:0]  cfg_ctrl;
  logic [127:0] cfg_pat, cfg_chk;
  logic [7:0]   fwd_data_o;
  logic         fwd_valid_o, fwd_sop_o;
  logic [5:0]   host_addr_i = '0;
  logic [7:0]   host_rdata_o;
  logic         host_clr_i = 1'b0;
  logic         host_avail_o, host_ovf_o;
  logic [1:0]   host_hit_o;

  assign cfg_ctrl = {ctl[3], ctl[2], ctl[1], ctl[0]};
  assign cfg_pat  = {pat[3], pat[2], pat[1], pat[0]};
  assign cfg_chk  = {chk[3], chk[2], chk[1], chk[0]};

  atm_hdr_filter i_atm_hdr_filter (
    .clk_i, .rst_ni, .cell_data_i, .cell_valid_i, .cell_sop_i,
    .cfg_ctrl_i(cfg_ctrl), .cfg_pattern_i(cfg_pat), .cfg_check_i(cfg_chk),
    .fwd_data_o, .fwd_valid_o, .fwd_sop_o,
    .host_addr_i, .host_rdata_o, .host_clr_i,
    .host_avail_o, .host_ovf_o, .host_hit_o
  );

  always #10 clk_i = ~clk_i;

  int vec_cnt = 0, err_cnt = 0, cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor
  logic [7:0] exp_b [53];
  int out_cnt = 0, data_err = 0, first_cyc = 0;
  logic first_sop = 1'b0;
  always @(negedge clk_i) begin
    if (fwd_valid_o) begin
      if (out_cnt == 0) begin
        first_cyc = cyc;
        first_sop = fwd_sop_o;
      end
      if (out_cnt < 53 && fwd_data_o != exp_b[out_cnt]) data_err++;
      out_cnt++;
    end
  end

  // reference model state
  logic       avail_m = 1'b0, ovf_m = 1'b0;
  logic [1:0] hit_m = '0;
  logic [7:0] buf_m [53];

  task automatic check(input logic ok, input string req, input string tag,
                       input longint act, input longint exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s (%s): got %0h expected %0h", req, tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] hdr, input logic [7:0] seed,
                       input int len, output int start);
    start = 0;
    for (int k = 0; k < len; k++) begin
      @(posedge clk_i); #1;
      if (k == 0) start = cyc;
      cell_valid_i = 1'b1;
      cell_sop_i   = (k == 0);
      cell_data_i  = (k < 4) ? hdr[31-8*k -: 8] : 8'(seed + k);
    end
    @(posedge clk_i); #1;
    cell_valid_i = 1'b0;
    cell_sop_i   = 1'b0;
    repeat (8) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic run_cell(input logic [31:0] hdr, input logic [7:0] seed, input string tag);
    logic cp, dr, a;
    logic [1:0] sel;
    int start;
    cp = 0; dr = 0; sel = 0;
    for (int f = 3; f >= 0; f--) begin
      a = ctl[f][3] & ((((hdr ^ pat[f]) & chk[f]) == 0) ^ ctl[f][0]);
      if (a && ctl[f][1]) dr = 1;
      if (a && ctl[f][2]) begin cp = 1; sel = 2'(f); end
    end
    for (int k = 0; k < 53; k++) exp_b[k] = (k < 4) ? hdr[31-8*k -: 8] : 8'(seed + k);
    out_cnt = 0; data_err = 0;
    drive(hdr, seed, 53, start);
    check(out_cnt == (dr ? 0 : 53), "R4 beat count", tag, out_cnt, dr ? 0 : 53);
    if (!dr) begin
      check(first_cyc == start + 4, "R5 latency", tag, first_cyc - start, 4);
      check(first_sop == 1'b1, "R5 sop marker", tag, first_sop, 1);
      check(data_err == 0, "R5 data", tag, data_err, 0);
    end
    if (cp) begin
      if (!avail_m) begin
        avail_m = 1; hit_m = sel;
        for (int k = 0; k < 53; k++) buf_m[k] = exp_b[k];
      end else ovf_m = 1;
    end
    check(host_avail_o == avail_m, "R6 avail", tag, host_avail_o, avail_m);
    check(host_ovf_o == ovf_m, "R9 overflow", tag, host_ovf_o, ovf_m);
    if (avail_m) check(host_hit_o == hit_m, "R8 hit id", tag, host_hit_o, hit_m);
  endtask

  task automatic read_and_clear(input string tag);
    int bad = 0;
    for (int a = 0; a < 53; a++) begin
      host_addr_i = 6'(a); #1;
      if (host_rdata_o != buf_m[a]) bad++;
    end
    check(bad == 0, "R6 buffer contents", tag, bad, 0);
    @(posedge clk_i); #1 host_clr_i = 1'b1;
    @(posedge clk_i); #1 host_clr_i = 1'b0;
    @(negedge clk_i);
    avail_m = 0; ovf_m = 0;
    check(!host_avail_o && !host_ovf_o, "R10 clear", tag, {host_avail_o, host_ovf_o}, 0);
  endtask

  task automatic cfg_all_off();
    for (int f = 0; f < 4; f++) begin ctl[f] = '0; pat[f] = '0; chk[f] = '0; end
  endtask

  initial begin
    #(200000 * 20);
    err_cnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    int st;
    cfg_all_off();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(!fwd_valid_o && !host_avail_o && !host_ovf_o, "R11 reset", "in reset",
          {fwd_valid_o, host_avail_o, host_ovf_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!fwd_valid_o && !host_avail_o && !host_ovf_o, "R11 reset", "after release",
          {fwd_valid_o, host_avail_o, host_ovf_o}, 0);

    // R1: disabled filters with every other bit set
    for (int f = 0; f < 4; f++) begin ctl[f] = 4'b0111; pat[f] = 32'hA1B2C3D4; chk[f] = '1; end
    run_cell(32'hA1B2C3D4, 8'h10, "R1 all disabled");
    cfg_all_off();

    // R2: mask compare
    ctl[0] = 4'b1010; pat[0] = 32'h12345678; chk[0] = 32'hFFFFFF00;
    run_cell(32'h12345678, 8'h20, "R2 exact match");
    run_cell(32'h123456EE, 8'h21, "R2 masked bits differ");
    run_cell(32'h12355678, 8'h22, "R2 compared bit differs");

    // R3: inverted sense
    ctl[0] = 4'b1011;
    run_cell(32'h12355678, 8'h30, "R3 mismatch selected");
    run_cell(32'h12345600, 8'h31, "R3 match passes");
    cfg_all_off();

    // R6 / R8: copy only
    ctl[2] = 4'b1100; pat[2] = 32'h0000_0F00; chk[2] = 32'h0000_FF00;
    run_cell(32'hFFFF0F77, 8'h40, "R6 copy only");
    read_and_clear("R6 copy only");

    // R7 / R8: copy+discard with two copiers
    ctl[1] = 4'b1100; pat[1] = 32'h0; chk[1] = 32'h0;
    ctl[3] = 4'b1110; pat[3] = 32'h0; chk[3] = 32'h0;
    ctl[2] = 4'b0000;
    run_cell(32'h01020304, 8'h50, "R7 copy and discard");
    // R9: second copy while full
    run_cell(32'h05060708, 8'h60, "R9 refused copy");
    read_and_clear("R9 old contents kept");
    cfg_all_off();

    // R12: fragment then full cell
    ctl[0] = 4'b1010; pat[0] = 32'hDEAD0000; chk[0] = 32'hFFFF0000;
    drive(32'hDEAD1111, 8'h70, 10, st);
    run_cell(32'hBEEF2222, 8'h71, "R12 restart after fragment");
    run_cell(32'hDEAD3333, 8'h72, "R12 drop after fragment");
    cfg_all_off();

    // sweep over filter configurations and headers
    for (int f = 0; f < 4; f++) pat[f] = 32'h12345600 | 32'(f);
    chk[0] = 32'hFFFFFFFF; chk[1] = 32'hFFFFFF00; chk[2] = 32'h0000000F; chk[3] = 32'h0;
    for (int i = 0; i < 160; i++) begin
      logic [31:0] h;
      for (int f = 0; f < 4; f++) ctl[f] = 4'((i * (f + 3) + f * 5 + (i >> 3)) % 16);
      h = 32'h12345600 | 32'(i % 5);
      if (i % 7 == 0) h = h ^ 32'h80000000;
      run_cell(h, 8'(i), "sweep");
      if (avail_m && (i % 3 != 0)) read_and_clear("sweep");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule